// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a down-counting watchdog for a low-power microcontroller. Software arms it by writing a reload value and then setting its enable bit. From then on, software must write a fixed key value to the refresh register often enough to stop the count from running out.

The first time the count runs out, the block raises an alert interrupt and starts counting again from the reload value. This gives software a window to shut the system down in an orderly way. If the count runs out a second time with no valid refresh in between, the block drives a reset pulse of fixed length. That pulse is meant for the digital domain only: the always-on real-time clock domain is not wired to it and keeps running. After the pulse, the watchdog returns to its power-on state and is disabled.

Writes come in through a simple single-cycle register port. Register offsets: 0 is the reload value, 1 is control, and 2 is refresh. In the control word, bit 0 enables the watchdog and bit 1 clears the alert.

Top module: `wdt_two_stage`

## Requirements
- R1: Once enabled, the counter starts from the reload value and counts down by one each cycle. The first expiry happens on the edge RELOAD+1 cycles after the enabling write. At that edge `alert_irq_o` rises and `wdt_rst_o` stays low.
- R2: At the first expiry the counter reloads. If no valid refresh follows, the second expiry happens RELOAD+1 cycles after the first, and `wdt_rst_o` rises at that edge.
- R3: A write of the key value (default 16'hC35A) to offset 2 while enabled reloads the counter, drops `alert_irq_o` on that edge and returns the block to the first stage. The next expiry then raises only the alert, RELOAD+1 cycles later.
- R4: A write of any other value to offset 2 is ignored and leaves the expiry times unchanged.
- R5: Writing control bit 1 drops `alert_irq_o` but does not change the count or the stage, so the reset still comes at its original time.
- R6: `wdt_rst_o` stays high for exactly RST_PULSE (default 16) consecutive cycles. `alert_irq_o` is low while it is high.
- R7: Entering the reset pulse disables the block and restores the reload value to RELOAD_RST (default 255). Writes made during the pulse are ignored.
- R8: While the block is enabled, writing 0 to control bit 0 has no effect. Only a reset disables the watchdog.
- R9: After `rst_ni` both outputs are low and the block stays disabled, producing no alert, until it is enabled.
- R10: A reload value written while the block is enabled takes effect only at the next reload. The count already running keeps its old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe, one cycle per write |
| wr_addr_i | input | ADDR_W (2) | Register offset: 0 reload, 1 control, 2 refresh |
| wr_data_i | input | DATA_W (16) | Write data |
| alert_irq_o | output | 1 | First-stage alert interrupt, level |
| wdt_rst_o | output | 1 | Digital-domain reset pulse |

## Verification
Most internal state of this block shows at the ports only through timing. A counter that starts from the wrong value, or a refresh that is wrongly accepted or dropped, moves the alert edge and the reset edge by whole cycles. The tests therefore check the cycle just before and the cycle of each expected edge. A stage register that is wrong, or an alert clear that leaks into the count, shows up at the second expiry: the block issues an alert where a reset was due, or the reverse. A faulty return to the disabled state shows up only after a full reload period with no output, so those checks wait past that period.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
   typedef enum logic [1:0] {
      WS_ARMED  = 2'd0,
      WS_WARNED = 2'd1,
      WS_PULSE  = 2'd2
   } wdt_state_e;

   localparam int REG_RELOAD   = 0;
   localparam int REG_CTRL     = 1;
   localparam int REG_KICK     = 2;
   localparam int CTRL_EN_BIT  = 0;
   localparam int CTRL_ACK_BIT = 1;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
   import wdt_pkg::*;
#(
   parameter int          ADDR_W     = 2,
   parameter int          DATA_W     = 16,
   parameter int          CNT_W      = 16,
   parameter int          KEY_W      = 16,
   parameter logic [15:0] KEY        = 16'hC35A,
   parameter int          RELOAD_RST = 255
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic              hold_i,
   input  logic              wipe_i,
   output logic [CNT_W-1:0]  reload_o,
   output logic              armed_o,
   output logic              arm_start_o,
   output logic              kick_o,
   output logic              ack_o
);
   logic wr_ok, sel_reload, sel_ctrl, sel_kick;
   logic [CNT_W-1:0] reload_q;
   logic armed_q;

   assign wr_ok      = wr_en_i && !hold_i;
   assign sel_reload = wr_ok && (wr_addr_i == ADDR_W'(REG_RELOAD));
   assign sel_ctrl   = wr_ok && (wr_addr_i == ADDR_W'(REG_CTRL));
   assign sel_kick   = wr_ok && (wr_addr_i == ADDR_W'(REG_KICK));

   assign arm_start_o = sel_ctrl && wr_data_i[CTRL_EN_BIT] && !armed_q;
   assign ack_o       = sel_ctrl && wr_data_i[CTRL_ACK_BIT];
   assign kick_o      = sel_kick && (wr_data_i[KEY_W-1:0] == KEY[KEY_W-1:0]);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         reload_q <= CNT_W'(RELOAD_RST);
         armed_q  <= 1'b0;
      end else if (wipe_i) begin
         reload_q <= CNT_W'(RELOAD_RST);
         armed_q  <= 1'b0;
      end else begin
         if (sel_reload)  reload_q <= wr_data_i[CNT_W-1:0];
         if (arm_start_o) armed_q  <= 1'b1;
      end
   end

   assign reload_o = reload_q;
   assign armed_o  = armed_q;

   // R8: once armed, only the pulse wipe may disarm
   p_enable_lock_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      armed_q && !wipe_i |=> armed_q);
   // R7: writes during the reset pulse cannot arm the block
   p_pulse_writes_ignored_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hold_i && !armed_q |=> !armed_q);
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             run_i,
   input  logic             load_i,
   input  logic [CNT_W-1:0] reload_i,
   output logic             expire_o
);
   logic [CNT_W-1:0] cnt_q;
   logic at_zero;

   assign at_zero  = (cnt_q == '0);
   assign expire_o = run_i && !load_i && at_zero;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              cnt_q <= '0;
      else if (load_i)          cnt_q <= reload_i;
      else if (run_i) begin
         if (at_zero)           cnt_q <= reload_i;
         else                   cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   // R1: a running, unloaded, non-zero count drops by exactly one
   p_count_down_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      run_i && !load_i && !at_zero |=> cnt_q == $past(cnt_q) - CNT_W'(1));
endmodule

// File: rtl/wdt_stage_fsm.sv
module wdt_stage_fsm
   import wdt_pkg::*;
#(
   parameter int RST_PULSE = 16
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic expire_i,
   input  logic kick_ok_i,
   input  logic ack_i,
   output logic alert_o,
   output logic rst_o,
   output logic wipe_o
);
   localparam int PW = (RST_PULSE > 1) ? $clog2(RST_PULSE) : 1;

   wdt_state_e state_q;
   logic alert_q, pulse_done;

   assign wipe_o = (state_q == WS_WARNED) && expire_i;
   assign rst_o  = (state_q == WS_PULSE);

   generate
      if (RST_PULSE > 1) begin : g_long_pulse
         logic [PW-1:0] pcnt_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)                                 pcnt_q <= '0;
            else if (wipe_o)                             pcnt_q <= PW'(RST_PULSE - 1);
            else if (state_q == WS_PULSE && pcnt_q != 0) pcnt_q <= pcnt_q - PW'(1);
         end
         assign pulse_done = (pcnt_q == '0);
      end else begin : g_single_pulse
         assign pulse_done = 1'b1;
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) state_q <= WS_ARMED;
      else begin
         unique case (state_q)
            WS_ARMED:  if (expire_i) state_q <= WS_WARNED;
            WS_WARNED: begin
               if (kick_ok_i)     state_q <= WS_ARMED;
               else if (expire_i) state_q <= WS_PULSE;
            end
            WS_PULSE:  if (pulse_done) state_q <= WS_ARMED;
            default:   state_q <= WS_ARMED;
         endcase
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               alert_q <= 1'b0;
      else if (wipe_o)                           alert_q <= 1'b0;
      else if (state_q == WS_ARMED && expire_i)  alert_q <= 1'b1;
      else if (kick_ok_i || ack_i)               alert_q <= 1'b0;
   end
   assign alert_o = alert_q;

   // checker-only run-length counter for the reset pulse
   int unsigned run_len;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    run_len <= 0;
      else if (rst_o) run_len <= run_len + 1;
      else            run_len <= 0;
   end

   // R2: the reset pulse only starts from the second stage
   p_rst_after_warn_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(rst_o) |-> $past(state_q) == WS_WARNED);
   // R6: alert is quiet during the pulse
   p_quiet_alert_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rst_o |-> !alert_o);
   // R6: pulse never exceeds its length
   p_pulse_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rst_o |-> run_len < RST_PULSE);
   // R6: pulse ends at exactly its length
   p_pulse_len_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(rst_o) |-> run_len == RST_PULSE);
endmodule

// File: rtl/wdt_two_stage.sv
module wdt_two_stage #(
   parameter int          ADDR_W     = 2,
   parameter int          DATA_W     = 16,
   parameter int          CNT_W      = 16,
   parameter int          KEY_W      = 16,
   parameter logic [15:0] KEY        = 16'hC35A,
   parameter int          RELOAD_RST = 255,
   parameter int          RST_PULSE  = 16
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   output logic              alert_irq_o,
   output logic              wdt_rst_o
);
   generate
      if (ADDR_W < 2)          begin : g_bad_addr  $error("ADDR_W must be at least 2"); end
      if (KEY_W > DATA_W || KEY_W > 16) begin : g_bad_key $error("KEY_W too wide"); end
      if (CNT_W > DATA_W || CNT_W < 2) begin : g_bad_cnt $error("CNT_W out of range"); end
      if (RST_PULSE < 1)       begin : g_bad_pulse $error("RST_PULSE must be positive"); end
      if (RELOAD_RST >= (1 << CNT_W) || RELOAD_RST < 0) begin : g_bad_rld $error("RELOAD_RST does not fit"); end
   endgenerate

   logic [CNT_W-1:0] reload;
   logic armed, arm_start, kick, ack, kick_ok, load, expire, wipe;

   assign kick_ok = kick && armed;
   assign load    = arm_start || kick_ok;

   wdt_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
      .KEY_W(KEY_W), .KEY(KEY), .RELOAD_RST(RELOAD_RST)
   ) u_regs (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
      .hold_i(wdt_rst_o), .wipe_i(wipe),
      .reload_o(reload), .armed_o(armed), .arm_start_o(arm_start),
      .kick_o(kick), .ack_o(ack)
   );

   wdt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .run_i(armed), .load_i(load), .reload_i(reload),
      .expire_o(expire)
   );

   wdt_stage_fsm #(.RST_PULSE(RST_PULSE)) u_fsm (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .expire_i(expire), .kick_ok_i(kick_ok), .ack_i(ack),
      .alert_o(alert_irq_o), .rst_o(wdt_rst_o), .wipe_o(wipe)
   );

   // R3: an accepted refresh drops the alert on that edge
   p_kick_clears_alert_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      kick_ok |=> !alert_irq_o);
   // R9: a disarmed block never raises an alert
   p_idle_silent_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !armed && !arm_start |=> !$rose(alert_irq_o));
endmodule

// File: tb/tb_wdt_two_stage.sv
module tb_wdt_two_stage;
   localparam int CLK_PERIOD = 10;
   localparam logic [15:0] KEY = 16'hC35A;
   localparam int R = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic [1:0] wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic alert, wrst;
   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   wdt_two_stage dut (
      .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
      .wr_data_i(wr_data), .alert_irq_o(alert), .wdt_rst_o(wrst)
   );

   task automatic chk(string tag, logic act, logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic wait_n(int n);
      repeat (n) @(negedge clk);
   endtask

   // called at a negedge; sampled at the next posedge; returns at the following negedge
   task automatic wr(logic [1:0] a, logic [15:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_addr = '0; wr_data = '0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      wait_n(2);
      rst_n = 1'b1;
      wait_n(1);
   endtask

   task automatic t_reset_state();
      do_reset();
      chk("R9 alert after reset", alert, 1'b0);
      chk("R9 rst after reset", wrst, 1'b0);
      wait_n(600);
      chk("R9 no alert while disabled", alert, 1'b0);
   endtask

   task automatic t_two_stages();
      do_reset();
      wr(2'd0, 16'(R));
      wr(2'd1, 16'h0001);                 // E0
      wait_n(R);     chk("R1 alert before first expiry", alert, 1'b0);
      wait_n(1);     chk("R1 alert at first expiry", alert, 1'b1);
                     chk("R1 no reset at first expiry", wrst, 1'b0);
      wait_n(R);     chk("R2 no reset before second expiry", wrst, 1'b0);
      wait_n(1);     chk("R2 reset at second expiry", wrst, 1'b1);
                     chk("R6 alert low during pulse", alert, 1'b0);
      wait_n(2);
      wr(2'd1, 16'h0001);                 // during pulse, ignored (R7)
      wait_n(12);    chk("R6 pulse still high at cycle 16", wrst, 1'b1);
      wait_n(1);     chk("R6 pulse low after 16 cycles", wrst, 1'b0);
      wait_n(300);   chk("R7 disabled after pulse", alert, 1'b0);
      wr(2'd1, 16'h0001);                 // reload back at 255
      wait_n(255);   chk("R7 reload default before expiry", alert, 1'b0);
      wait_n(1);     chk("R7 reload default at expiry", alert, 1'b1);
   endtask

   task automatic t_refresh();
      do_reset();
      wr(2'd0, 16'(R));
      wr(2'd1, 16'h0001);                 // E0
      wait_n(9);
      wr(2'd2, 16'h1234);                 // E10, wrong key
      wait_n(10);    chk("R4 wrong key, no early alert", alert, 1'b0);
      wait_n(1);     chk("R4 wrong key ignored, alert on time", alert, 1'b1);
      wait_n(4);
      wr(2'd2, KEY);                      // E26
      chk("R3 refresh clears alert", alert, 1'b0);
      wait_n(20);    chk("R3 no alert before new expiry", alert, 1'b0);
      wait_n(1);     chk("R3 first stage again: alert", alert, 1'b1);
                     chk("R3 first stage again: no reset", wrst, 1'b0);
   endtask

   task automatic t_lock_and_ack();
      do_reset();
      wr(2'd0, 16'(R));
      wr(2'd1, 16'h0001);                 // E0
      wait_n(9);
      wr(2'd1, 16'h0000);                 // E10, disable attempt
      wait_n(10);    chk("R8 no alert early", alert, 1'b0);
      wait_n(1);     chk("R8 still enabled, alert", alert, 1'b1);
      wait_n(4);
      wr(2'd1, 16'h0003);                 // E26, alert clear
      chk("R5 alert cleared", alert, 1'b0);
      wait_n(15);    chk("R5 no reset early", wrst, 1'b0);
      wait_n(1);     chk("R5 reset on original schedule", wrst, 1'b1);
   endtask

   task automatic t_reload_change();
      do_reset();
      wr(2'd0, 16'(R));
      wr(2'd1, 16'h0001);                 // E0
      wait_n(4);
      wr(2'd0, 16'd10);                   // E5
      wait_n(15);    chk("R10 old count kept, no alert", alert, 1'b0);
      wait_n(1);     chk("R10 old count kept, alert", alert, 1'b1);
      wait_n(10);    chk("R10 new reload, no reset yet", wrst, 1'b0);
      wait_n(1);     chk("R10 new reload used for second stage", wrst, 1'b1);
   endtask

   initial begin
      @(negedge clk);
      t_reset_state();
      t_two_stages();
      t_refresh();
      t_lock_and_ack();
      t_reload_change();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (100000) @(posedge clk);
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
         end
      join_any
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule